// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns asynchronous interrupt pins into interrupt request flags for a processor core. It watches a small set of dedicated interrupt pins and a wider group of pin-change inputs. Each dedicated pin has a per-pin sense setting: low level, falling edge, rising edge, or off. Any toggle on a pin of the pin-change group whose mask bit is set raises one shared flag for the whole group. Every pin is read as the value on the pad, or as the driven value when its output driver is enabled. Software can therefore raise an interrupt by driving the pin itself.

The controller keeps two clock domains apart. One is an always-running sampling clock. The other is a gated I/O clock, modelled as a clock-enable input. Edge recognition on the dedicated pins happens only in cycles where the I/O clock runs, so an edge that occurs while the I/O clock is stopped is lost. Low-level sensing and pin-change sensing still work while the I/O clock is stopped, and they drive a wake request that can bring the core out of sleep. Edge-type flags are sticky until the core acknowledges them. Level requests are not latched and follow the pin.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every flag, every request output and the wake request are 0.
- R2: The sense field of dedicated pin i is `ext_sense[2i+1:2i]`, encoded as 00 low level, 01 off (never requests), 10 falling edge, 11 rising edge.
- R3: In low-level mode, `ext_irq[i]` is high while the pin is enabled and its synchronized value is 0. This takes effect SYNC_STAGES cycles after the pad change and does not depend on `io_clk_en`. The request is not latched and drops once the pin returns high. `ext_flag[i]` is not set by a level.
- R4: In an edge mode, `ext_flag[i]` sets one cycle after the synchronized value shows the selected transition, which is SYNC_STAGES+1 edges after the pad change. It sets only if `io_clk_en` is 1 in that cycle. An edge seen with `io_clk_en` low is lost and is not recovered when the I/O clock restarts.
- R5: `pc_flag` sets when a pin-change input whose bit is 1 in `pc_mask` toggles, with the same latency as R4, whatever the value of `io_clk_en`. Toggles on masked-off inputs leave it unchanged.
- R6: Edge and pin-change flags stay set until their acknowledge input is high on a clock edge. If a new event and the acknowledge fall on the same edge, the flag remains set.
- R7: An enable bit per source gates its request output (`ext_irq[i]` needs `ext_en[i]`, `pc_irq` needs `pc_en`). The flags keep recording events while the source is disabled.
- R8: The value sensed on every pin is `out` when its `oe` bit is 1, and the pad input otherwise. Driving a pin as an output therefore triggers its interrupt.
- R9: `wake_req` is the OR of the enabled low-level requests and the enabled pending pin-change flag. Edge flags never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_clk_en | input | 1 | 1 while the gated I/O clock runs |
| ext_pad_in | input | NUM_EXT | Pad values of the dedicated interrupt pins |
| ext_oe | input | NUM_EXT | Output-driver enable of the dedicated pins |
| ext_out | input | NUM_EXT | Driven value of the dedicated pins |
| ext_sense | input | 2*NUM_EXT | Per-pin sense field (R2) |
| ext_en | input | NUM_EXT | Request enable per dedicated pin |
| ext_ack | input | NUM_EXT | Flag acknowledge per dedicated pin |
| pc_pad_in | input | PC_WIDTH | Pad values of the pin-change group |
| pc_oe | input | PC_WIDTH | Output-driver enable of the group pins |
| pc_out | input | PC_WIDTH | Driven value of the group pins |
| pc_mask | input | PC_WIDTH | Selects which group pins may set the shared flag |
| pc_en | input | 1 | Request enable of the pin-change group |
| pc_ack | input | 1 | Acknowledge of the pin-change flag |
| ext_flag | output | NUM_EXT | Sticky edge flags of the dedicated pins |
| ext_irq | output | NUM_EXT | Request per dedicated pin |
| pc_flag | output | 1 | Sticky pin-change flag |
| pc_irq | output | 1 | Pin-change request |
| wake_req | output | 1 | Wake request available with the I/O clock stopped |

## Verification
The bench builds the controller with two dedicated pins, an eight-wide group and SYNC_STAGES set to 3 rather than the default 2. Any latency that is accidentally hard-wired to two synchronizer stages therefore shows up as an off-by-one against the reference queue. The longer pipeline also leaves room to drop the I/O clock enable between a pad change and the cycle in which the edge is judged. This exercises the lost-edge case and the pin-change wake path with the I/O clock stopped. It also leaves room to place an acknowledge on exactly the edge where a new event sets the flag.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_OFF  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int SENSE_W = 2;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);

  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d[W-1:0] = din_i;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s*W +: W] = chain_q[(s-1)*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout_o = chain_q[(STAGES-1)*W +: W];

endmodule

// File: rtl/ext_sense_unit.sv
module ext_sense_unit
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   io_clk_en_i,
  input  logic   lvl_i,
  input  sense_e mode_i,
  input  logic   en_i,
  input  logic   ack_i,
  output logic   flag_o,
  output logic   irq_o,
  output logic   wake_o
);

  logic prev_q;
  logic flag_q;
  logic flag_d;
  logic flag_upd;
  logic edge_seen;
  logic edge_hit;
  logic level_hit;
  logic edge_mode;

  // next state
  always_comb begin
    case (mode_i)
      SENSE_FALL: edge_seen = prev_q & ~lvl_i;
      SENSE_RISE: edge_seen = ~prev_q & lvl_i;
      default:    edge_seen = 1'b0;
    endcase
    edge_hit  = edge_seen & io_clk_en_i;
    level_hit = (mode_i == SENSE_LOW) & ~lvl_i;
    edge_mode = (mode_i == SENSE_FALL) | (mode_i == SENSE_RISE);
    flag_upd  = edge_hit | ack_i;
    flag_d    = flag_q;
    if (ack_i)    flag_d = 1'b0;
    if (edge_hit) flag_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (flag_upd) flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = en_i & (level_hit | (edge_mode & flag_q));
  assign wake_o = en_i & level_hit;

  // R4: a flag can only appear on a cycle where the I/O clock ran
  assert_edge_needs_ioclk_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(io_clk_en_i)
  );

  // R6: a flag only falls after an acknowledge
  assert_flag_clears_on_ack_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(ack_i)
  );

endmodule

// File: rtl/pc_detect_unit.sv
module pc_detect_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  input  logic         ack_i,
  output logic         flag_o,
  output logic         irq_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] toggled;
  logic         hit;
  logic         flag_q;
  logic         flag_d;
  logic         flag_upd;

  // next state
  always_comb begin
    toggled  = (lvl_i ^ prev_q) & mask_i;
    hit      = |toggled;
    flag_upd = hit | ack_i;
    flag_d   = flag_q;
    if (ack_i) flag_d = 1'b0;
    if (hit)   flag_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (flag_upd) flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = en_i & flag_q;

  // R6: the shared flag only falls after an acknowledge
  assert_pc_clear_on_ack_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(ack_i)
  );

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_EXT     = 2,
  parameter int PC_WIDTH    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    io_clk_en,
  input  logic [NUM_EXT-1:0]      ext_pad_in,
  input  logic [NUM_EXT-1:0]      ext_oe,
  input  logic [NUM_EXT-1:0]      ext_out,
  input  logic [2*NUM_EXT-1:0]    ext_sense,
  input  logic [NUM_EXT-1:0]      ext_en,
  input  logic [NUM_EXT-1:0]      ext_ack,
  input  logic [PC_WIDTH-1:0]     pc_pad_in,
  input  logic [PC_WIDTH-1:0]     pc_oe,
  input  logic [PC_WIDTH-1:0]     pc_out,
  input  logic [PC_WIDTH-1:0]     pc_mask,
  input  logic                    pc_en,
  input  logic                    pc_ack,
  output logic [NUM_EXT-1:0]      ext_flag,
  output logic [NUM_EXT-1:0]      ext_irq,
  output logic                    pc_flag,
  output logic                    pc_irq,
  output logic                    wake_req
);

  localparam int RST_STAGES = 2;

  logic                rst_core_n;
  logic [NUM_EXT-1:0]  ext_pin_val;
  logic [PC_WIDTH-1:0] pc_pin_val;
  logic [NUM_EXT-1:0]  ext_lvl;
  logic [PC_WIDTH-1:0] pc_lvl;
  logic [NUM_EXT-1:0]  ext_wake;

  rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // pin value seen by the sensing logic: driven value wins when the driver is on
  always_comb begin
    ext_pin_val = (ext_oe & ext_out) | (~ext_oe & ext_pad_in);
    pc_pin_val  = (pc_oe & pc_out) | (~pc_oe & pc_pad_in);
  end

  pin_sync #(.W(NUM_EXT), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_ext_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .din_i  (ext_pin_val),
    .dout_o (ext_lvl)
  );

  pin_sync #(.W(PC_WIDTH), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_pc_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .din_i  (pc_pin_val),
    .dout_o (pc_lvl)
  );

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    ext_sense_unit u_sense (
      .clk         (clk),
      .rst_n       (rst_core_n),
      .io_clk_en_i (io_clk_en),
      .lvl_i       (ext_lvl[i]),
      .mode_i      (sense_e'(ext_sense[SENSE_W*i +: SENSE_W])),
      .en_i        (ext_en[i]),
      .ack_i       (ext_ack[i]),
      .flag_o      (ext_flag[i]),
      .irq_o       (ext_irq[i]),
      .wake_o      (ext_wake[i])
    );

    // R7: no request leaves a disabled pin
    assert_irq_needs_enable_R7: assert property (
      @(posedge clk) disable iff (!rst_core_n)
      ext_irq[i] |-> ext_en[i]
    );
  end

  pc_detect_unit #(.W(PC_WIDTH)) u_pc (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .lvl_i  (pc_lvl),
    .mask_i (pc_mask),
    .en_i   (pc_en),
    .ack_i  (pc_ack),
    .flag_o (pc_flag),
    .irq_o  (pc_irq)
  );

  assign wake_req = (|ext_wake) | pc_irq;

  // R9: a wake request is always backed by a visible request
  assert_wake_has_request_R9: assert property (
    @(posedge clk) disable iff (!rst_core_n)
    wake_req |-> ((|ext_irq) || pc_irq)
  );

  // R5: the shared flag only rises after the synchronized group changed
  assert_pc_flag_after_change_R5: assert property (
    @(posedge clk) disable iff (!rst_core_n)
    $rose(pc_flag) |-> ($past(pc_lvl) != $past(pc_lvl, 2))
  );

endmodule

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;

  localparam int NE = 2;
  localparam int PW = 8;
  localparam int L  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          io_clk_en = 1'b1;
  logic [NE-1:0] ext_pad_in = '1, ext_oe = '0, ext_out = '0, ext_en = '0, ext_ack = '0;
  logic [2*NE-1:0] ext_sense = '0;
  logic [PW-1:0] pc_pad_in = '1, pc_oe = '0, pc_out = '0, pc_mask = '0;
  logic          pc_en = 1'b0, pc_ack = 1'b0;
  logic [NE-1:0] ext_flag, ext_irq;
  logic          pc_flag, pc_irq, wake_req;

  int tests = 0;
  int fails = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  ext_irq_ctrl #(.NUM_EXT(NE), .PC_WIDTH(PW), .SYNC_STAGES(L)) i_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .io_clk_en(io_clk_en),
    .ext_pad_in(ext_pad_in), .ext_oe(ext_oe), .ext_out(ext_out),
    .ext_sense(ext_sense), .ext_en(ext_en), .ext_ack(ext_ack),
    .pc_pad_in(pc_pad_in), .pc_oe(pc_oe), .pc_out(pc_out),
    .pc_mask(pc_mask), .pc_en(pc_en), .pc_ack(pc_ack),
    .ext_flag(ext_flag), .ext_irq(ext_irq), .pc_flag(pc_flag),
    .pc_irq(pc_irq), .wake_req(wake_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model: queues of sensed pin values -------------
  logic [NE-1:0] qe[$];
  logic [PW-1:0] qp[$];
  logic [NE-1:0] m_ef;
  logic          m_pf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qe = {}; qp = {};
      for (int k = 0; k < L + 2; k++) begin qe.push_front('1); qp.push_front('1); end
      m_ef = '0; m_pf = 1'b0;
    end else begin
      logic [PW-1:0] tog;
      qe.push_front((ext_oe & ext_out) | (~ext_oe & ext_pad_in));
      void'(qe.pop_back());
      qp.push_front((pc_oe & pc_out) | (~pc_oe & pc_pad_in));
      void'(qp.pop_back());
      for (int i = 0; i < NE; i++) begin
        bit now_v, old_v, hit;
        int md;
        now_v = qe[L][i];
        old_v = qe[L+1][i];
        md = int'(ext_sense[2*i +: 2]);
        hit = io_clk_en && ((md == 2 && old_v && !now_v) || (md == 3 && !old_v && now_v));
        if (ext_ack[i]) m_ef[i] = 1'b0;
        if (hit)        m_ef[i] = 1'b1;
      end
      tog = (qp[L] ^ qp[L+1]) & pc_mask;
      if (pc_ack) m_pf = 1'b0;
      if (tog != 0) m_pf = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      logic [NE-1:0] e_irq;
      logic          e_wake;
      e_wake = m_pf & pc_en;
      for (int i = 0; i < NE; i++) begin
        int md;
        md = int'(ext_sense[2*i +: 2]);
        e_irq[i] = ext_en[i] && ((md == 0 && !qe[L-1][i]) || (md >= 2 && m_ef[i]));
        if (ext_en[i] && md == 0 && !qe[L-1][i]) e_wake = 1'b1;
      end
      chk(ext_flag === m_ef, "R4 model ext_flag", ext_flag, m_ef);
      chk(ext_irq === e_irq, "R3 model ext_irq", ext_irq, e_irq);
      chk(pc_flag === m_pf, "R5 model pc_flag", pc_flag, m_pf);
      chk(pc_irq === (m_pf & pc_en), "R7 model pc_irq", pc_irq, m_pf & pc_en);
      chk(wake_req === e_wake, "R9 model wake_req", wake_req, e_wake);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- directed and random stimulus ----------------
  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(6);
    chk(ext_flag == 0 && ext_irq == 0 && !pc_flag && !pc_irq && !wake_req,
        "R1 reset state", {ext_flag, ext_irq, pc_flag, pc_irq, wake_req}, 0);
    cmp_on = 1'b1;

    // R3 / R2 low level with the I/O clock stopped
    ext_sense = 4'b0100;           // pin0 low level, pin1 off
    ext_en = 2'b11;
    io_clk_en = 1'b0;
    ext_pad_in[0] = 1'b0;
    cyc(L - 1);
    chk(ext_irq[0] == 1'b0, "R3 level not yet synchronized", ext_irq[0], 0);
    cyc(1);
    chk(ext_irq[0] == 1'b1, "R3 low level request", ext_irq[0], 1);
    chk(wake_req == 1'b1, "R9 wake from level with io clock off", wake_req, 1);
    ext_pad_in[1] = 1'b0;          // pin1 off: never requests
    cyc(L + 2);
    chk(ext_irq[1] == 1'b0 && ext_flag[1] == 1'b0, "R2 off mode silent", {ext_irq[1], ext_flag[1]}, 0);
    ext_pad_in = 2'b11;
    cyc(L + 1);
    chk(ext_irq[0] == 1'b0 && ext_flag[0] == 1'b0, "R3 level not latched", {ext_irq[0], ext_flag[0]}, 0);

    // R4 falling edge with the I/O clock running
    io_clk_en = 1'b1;
    ext_sense = 4'b1000;           // pin1 falling
    ext_pad_in[1] = 1'b0;
    cyc(L);
    chk(ext_flag[1] == 1'b0, "R4 flag latency", ext_flag[1], 0);
    cyc(1);
    chk(ext_flag[1] == 1'b1 && ext_irq[1] == 1'b1, "R4 falling edge flag", {ext_flag[1], ext_irq[1]}, 3);
    chk(wake_req == 1'b0, "R9 edge flag gives no wake", wake_req, 0);
    ext_ack[1] = 1'b1; cyc(1); ext_ack[1] = 1'b0;
    chk(ext_flag[1] == 1'b0, "R6 ack clears flag", ext_flag[1], 0);
    ext_pad_in[1] = 1'b1;          // rising while falling selected
    cyc(L + 3);
    chk(ext_flag[1] == 1'b0, "R2 wrong polarity ignored", ext_flag[1], 0);

    // R4 rising edge lost while the I/O clock is stopped
    ext_sense = 4'b1100;
    ext_pad_in[1] = 1'b0; cyc(L + 3);
    chk(ext_flag[1] == 1'b0, "R4 falling ignored in rising mode", ext_flag[1], 0);
    io_clk_en = 1'b0;
    ext_pad_in[1] = 1'b1; cyc(L + 3);
    io_clk_en = 1'b1; cyc(4);
    chk(ext_flag[1] == 1'b0, "R4 edge lost without io clock", ext_flag[1], 0);

    // R7 flag recorded while disabled
    ext_en = 2'b00;
    ext_pad_in[1] = 1'b0; cyc(1); ext_pad_in[1] = 1'b1; cyc(L + 3);
    chk(ext_flag[1] == 1'b1 && ext_irq[1] == 1'b0, "R7 disabled pin keeps flag", {ext_flag[1], ext_irq[1]}, 2);
    ext_en = 2'b11; cyc(1);
    chk(ext_irq[1] == 1'b1, "R7 enable exposes pending flag", ext_irq[1], 1);

    // R6 acknowledge on the same edge as a new event: flag stays
    ext_pad_in[1] = 1'b0; cyc(2);
    ext_pad_in[1] = 1'b1;
    cyc(L);
    ext_ack[1] = 1'b1; cyc(1); ext_ack[1] = 1'b0;
    chk(ext_flag[1] == 1'b1, "R6 set wins over ack", ext_flag[1], 1);
    ext_ack[1] = 1'b1; cyc(1); ext_ack[1] = 1'b0;

    // R8 driven output triggers a level request
    ext_sense = 4'b0000;
    ext_oe[0] = 1'b1; ext_out[0] = 1'b0;
    cyc(L + 1);
    chk(ext_irq[0] == 1'b1, "R8 driven pin triggers", ext_irq[0], 1);
    ext_oe[0] = 1'b0; cyc(L + 1);

    // R5 pin-change group
    pc_mask = 8'h0F; pc_en = 1'b1;
    pc_pad_in[6] = 1'b0; cyc(L + 3);
    chk(pc_flag == 1'b0, "R5 masked-off toggle ignored", pc_flag, 0);
    io_clk_en = 1'b0;
    pc_pad_in[2] = 1'b0; cyc(L + 2);
    chk(pc_flag == 1'b1 && wake_req == 1'b1, "R5 toggle sets flag with io clock off", {pc_flag, wake_req}, 3);
    io_clk_en = 1'b1;
    pc_ack = 1'b1; cyc(1); pc_ack = 1'b0;
    chk(pc_flag == 1'b0, "R6 pin-change ack", pc_flag, 0);
    pc_oe[1] = 1'b1; pc_out[1] = 1'b0; cyc(L + 2);
    chk(pc_flag == 1'b1, "R8 driven group pin toggles", pc_flag, 1);
    pc_ack = 1'b1; cyc(1); pc_ack = 1'b0;

    // random phase checked against the model every clock
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(7) == 0) ext_pad_in ^= 2'($urandom_range(3));
      if ($urandom_range(7) == 0) pc_pad_in ^= 8'(1 << $urandom_range(7));
      if ($urandom_range(31) == 0) ext_sense = 4'($urandom);
      if ($urandom_range(31) == 0) ext_en = 2'($urandom);
      if ($urandom_range(31) == 0) pc_mask = 8'($urandom);
      if ($urandom_range(31) == 0) pc_en = 1'($urandom);
      if ($urandom_range(63) == 0) begin ext_oe = 2'($urandom); ext_out = 2'($urandom); end
      if ($urandom_range(63) == 0) begin pc_oe = 8'($urandom); pc_out = 8'($urandom); end
      if ($urandom_range(15) == 0) io_clk_en = ~io_clk_en;
      ext_ack = ($urandom_range(5) == 0) ? 2'($urandom) : 2'b00;
      pc_ack  = ($urandom_range(5) == 0);
      cyc(1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule